// File: doc/BRIEF.md
# Training-Word Bitslip Alignment Controller

This block sits in the word-rate (divided) clock domain beside a serial-to-parallel converter. It looks at each parallel word the converter produces, and while that word is not the expected training word it asks the converter to shift its word boundary by one bit. It does this with a one-cycle slip pulse. After each pulse it gives the converter a fixed number of word clocks to settle before it looks again. The settle time is two cycles for single-rate capture and three cycles for double-rate capture.

When the word matches the training word, the controller raises its lock flag and stops searching. It keeps the lock whatever data follows, until reset. The training word is an input port, so each link can set its own. Upstream logic is expected to send the training word repeatedly during link bring-up.

The state machine has four states:
- SEARCH compares the word.
- SLIP drives the pulse for one cycle and loads the settle timer.
- WAIT holds until the timer expires.
- LOCKED is terminal.

The transitions are:
- SEARCH→LOCKED on a match.
- SEARCH→SLIP on a mismatch.
- SLIP→WAIT always.
- WAIT→SEARCH when the timer expires.
- LOCKED→LOCKED always.

Top module: `bitslip_aligner`

## Requirements
- R1: After reset the controller is in SEARCH: `lock_flag` is 0 and `slip_pulse` is 0 in the first cycle.
- R2: `slip_pulse` is high for exactly one cycle per slip request.
- R3: After a slip pulse, the controller waits 2 cycles (`ddr_mode`=0) or 3 cycles (`ddr_mode`=1) before its next comparison. Consecutive slip pulses are therefore 4 or 5 cycles apart.
- R4: If `word_in` equals `train_word` during a SEARCH cycle, `lock_flag` is 1 from the next cycle on. If it differs, `slip_pulse` is 1 in the next cycle.
- R5: Once `lock_flag` is 1, it stays 1 whatever `word_in` and `train_word` do, until reset.
- R6: `slip_pulse` is never high while `lock_flag` is 1.
- R7: Reset clears `lock_flag` and restarts the search.
- R8: The training word is taken from the `train_word` port, so any 8-bit value works (the bench uses 0xEB as its default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| ddr_mode | input | 1 | 0 = single-rate settle time (2), 1 = double-rate settle time (3) |
| word_in | input | WORD_W | Parallel word from the deserializer |
| train_word | input | WORD_W | Expected training word |
| slip_pulse | output | 1 | One-cycle request to shift the word boundary |
| lock_flag | output | 1 | High once the training word has been found |

## Verification
The bench models a deserializer whose output word rotates by one bit on every slip pulse. It sweeps all eight starting rotations in both capture modes. The lock must appear exactly at k·(settle+2)+1 cycles after reset, and exactly k slips must be issued. A design with a wrong settle count would lock in the wrong cycle. A design that compares during WAIT would lock early, and one that slips on a match would lock late or never.

After lock, the bench feeds junk words and changes the training word. A design that re-checks alignment would slip again or drop the lock. A further run resets after lock and checks that the flag clears. Another run uses a non-default training word to show that the pattern comes from the port.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_SLIP   = 2'd1,
        ST_WAIT   = 2'd2,
        ST_LOCKED = 2'd3
    } bsa_state_t;
endpackage

// File: rtl/bsa_match.sv
module bsa_match #(
    parameter int WORD_W = 8
) (
    input  logic [WORD_W-1:0] word_in,
    input  logic [WORD_W-1:0] train_word,
    output logic              hit
);
    logic [WORD_W-1:0] bit_eq;

    genvar g;
    generate
        for (g = 0; g < WORD_W; g++) begin : g_bit
            assign bit_eq[g] = ~(word_in[g] ^ train_word[g]);
        end
    endgenerate

    assign hit = &bit_eq;
endmodule

// File: rtl/bsa_settle.sv
module bsa_settle #(
    parameter int SDR_WAIT = 2,
    parameter int DDR_WAIT = 3,
    localparam int MAX_WAIT = (SDR_WAIT > DDR_WAIT) ? SDR_WAIT : DDR_WAIT,
    localparam int CNT_W = (MAX_WAIT < 2) ? 1 : $clog2(MAX_WAIT)
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic ddr_mode,
    output logic expired
);
    localparam logic [CNT_W-1:0] SDR_LOAD = CNT_W'(SDR_WAIT - 1);
    localparam logic [CNT_W-1:0] DDR_LOAD = CNT_W'(DDR_WAIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= ddr_mode ? DDR_LOAD : SDR_LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R3: the counter is armed right after a load and never wraps.
    assert_timer_armed_R3: assert property (@(posedge clk) disable iff (rst)
        (load && (DDR_LOAD != '0) && (SDR_LOAD != '0)) |=> !expired);
    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (expired && !load) |=> expired);
endmodule

// File: rtl/bsa_fsm.sv
module bsa_fsm
    import bsa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic expired,
    output logic arm_timer,
    output logic slip_pulse,
    output logic lock_flag
);
    bsa_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_SEARCH: st_d = hit ? ST_LOCKED : ST_SLIP;
            ST_SLIP:   st_d = ST_WAIT;
            ST_WAIT:   st_d = expired ? ST_SEARCH : ST_WAIT;
            ST_LOCKED: st_d = ST_LOCKED;
            default:   st_d = ST_SEARCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_SEARCH;
        else     st_q <= st_d;
    end

    always_comb begin
        slip_pulse = 1'b0;
        lock_flag  = 1'b0;
        arm_timer  = 1'b0;
        unique case (st_q)
            ST_SEARCH: ;
            ST_SLIP: begin
                slip_pulse = 1'b1;
                arm_timer  = 1'b1;
            end
            ST_WAIT:   ;
            ST_LOCKED: lock_flag = 1'b1;
            default:   ;
        endcase
    end

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        slip_pulse |=> !slip_pulse);
    assert_settle_gap_R3: assert property (@(posedge clk) disable iff (rst)
        slip_pulse |=> !slip_pulse ##1 !slip_pulse ##1 !slip_pulse);
    assert_match_locks_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SEARCH && hit) |=> lock_flag);
    assert_miss_slips_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SEARCH && !hit) |=> slip_pulse);
    assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        lock_flag |=> lock_flag);
    assert_quiet_locked_R6: assert property (@(posedge clk) disable iff (rst)
        lock_flag |-> !slip_pulse);
endmodule

// File: rtl/bitslip_aligner.sv
module bitslip_aligner #(
    parameter int WORD_W   = 8,
    parameter int SDR_WAIT = 2,
    parameter int DDR_WAIT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ddr_mode,
    input  logic [WORD_W-1:0] word_in,
    input  logic [WORD_W-1:0] train_word,
    output logic              slip_pulse,
    output logic              lock_flag
);
    logic hit, expired, arm_timer;

    bsa_match #(.WORD_W(WORD_W)) u_match (
        .word_in    (word_in),
        .train_word (train_word),
        .hit        (hit)
    );

    bsa_settle #(.SDR_WAIT(SDR_WAIT), .DDR_WAIT(DDR_WAIT)) u_settle (
        .clk      (clk),
        .rst      (rst),
        .load     (arm_timer),
        .ddr_mode (ddr_mode),
        .expired  (expired)
    );

    bsa_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .hit        (hit),
        .expired    (expired),
        .arm_timer  (arm_timer),
        .slip_pulse (slip_pulse),
        .lock_flag  (lock_flag)
    );

    // R7: the first cycle after reset is never locked.
    assert_reset_clears_R7: assert property (@(posedge clk)
        $past(rst) |-> !lock_flag);
endmodule

// File: tb/test_bitslip_aligner.sv
module test_bitslip_aligner;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ddr_mode = 1'b0;
    logic [7:0] word_in = 8'h00;
    logic [7:0] train_word = 8'hEB;
    logic       slip_pulse, lock_flag;

    int n_checks = 0;
    int n_fail = 0;
    int offset;

    always #2 clk = ~clk;

    bitslip_aligner i_bitslip_aligner (
        .clk(clk), .rst(rst), .ddr_mode(ddr_mode),
        .word_in(word_in), .train_word(train_word),
        .slip_pulse(slip_pulse), .lock_flag(lock_flag)
    );

    function automatic logic [7:0] rotl(input logic [7:0] w, input int s);
        int r = s % 8;
        return (r == 0) ? w : ((w << r) | (w >> (8 - r)));
    endfunction

    task automatic check(input string req, input int actual, input int expected, input string what);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Runs one alignment: the modelled deserializer output is pattern rotated by start+slips.
    task automatic run_align(input logic [7:0] pat, input bit ddr, input int start);
        int settle = ddr ? 3 : 2;
        int k = (8 - start) % 8;
        int exp_lock = k * (settle + 2) + 1;
        int lock_at = -1;
        int slips = 0;
        int last_slip = -100;
        int min_gap = 1000;
        int after_slips = 0;
        int drops = 0;
        @(negedge clk);
        rst = 1'b1; ddr_mode = ddr; train_word = pat; offset = start;
        word_in = rotl(pat, offset);
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        for (int n = 0; n < exp_lock + 40; n++) begin
            if (n == 0) begin
                check("R1", lock_flag, 0, "lock after reset");
                check("R1", slip_pulse, 0, "slip after reset");
            end
            if (lock_flag && lock_at < 0) lock_at = n;
            if (slip_pulse) begin
                if (lock_at >= 0) after_slips++;
                slips++;
                if (n - last_slip < min_gap) min_gap = n - last_slip;
                last_slip = n;
                offset++;
            end
            if (lock_at >= 0 && !lock_flag) drops++;
            if (lock_at >= 0 && n > lock_at + 2) begin
                word_in = 8'h5A ^ 8'(n * 37);
                train_word = ~pat;
            end else begin
                word_in = rotl(pat, offset);
            end
            @(negedge clk);
        end
        check("R4", lock_at, exp_lock, $sformatf("lock cycle mode=%0d start=%0d", ddr, start));
        check("R4", slips, k, "slip count");
        if (k > 1) check("R3", min_gap, settle + 2, "pulse spacing");
        check("R6", after_slips, 0, "slips after lock");
        check("R5", drops, 0, "lock drops after junk");
    endtask

    initial begin
        #(4 * 100000);
        n_fail++; n_checks++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 8; s++)
                run_align(8'hEB, bit'(m), s);
        // R8: a different training word from the port
        run_align(8'h35, 1'b0, 3);
        run_align(8'h35, 1'b1, 6);
        // R2: the pulse width is one cycle; observe consecutive samples
        @(negedge clk); rst = 1'b1; train_word = 8'hEB; word_in = 8'h00; ddr_mode = 1'b0;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R2", slip_pulse, 1, "pulse present");
        @(negedge clk);
        check("R2", slip_pulse, 0, "pulse one cycle");
        // R7: lock then reset
        word_in = 8'hEB;
        repeat (6) @(negedge clk);
        check("R7", lock_flag, 1, "locked before reset");
        rst = 1'b1; word_in = 8'h11;
        @(negedge clk); rst = 1'b0;
        check("R7", lock_flag, 0, "lock cleared");
        @(negedge clk);
        check("R7", slip_pulse, 1, "search restarted");
        summary();
    end
endmodule